// File: doc/BRIEF.md
# Aliased Chip-Select Decoder with Remappable Vector Area

This block turns the 13-bit address of a small processor into chip selects for two 1K external RAM banks and for a combined peripheral device. The peripheral holds a 1K ROM, 64 bytes of scratch RAM and a 64-byte I/O window. The decode is deliberately minimal. The top three address bits choose one of eight 1K slots. The low ten bits pass straight through to whichever device responds. Most devices therefore appear at several aliased addresses.

The block also holds an 8-bit output port register, which software writes through the I/O window. One bit of that register controls the top 1K slot. When the bit is 1, the slot is served by ROM, so the processor fetches its reset vector from ROM. When the bit is 0, the top 64 bytes of the slot, 0x1FC0 to 0x1FFF, come from the scratch RAM, so software can rewrite the vectors. All selects are combinational from the current address and the current register value. The register changes only on a clock edge.

Top module: `addr_alias_decoder`

## Requirements
- R1: With the enable high, an address whose bits 12:10 are 000 selects RAM bank 0, and 001 selects RAM bank 1. The offset output always equals address bits 9:0.
- R2: With the enable high, any address with bit 12 = 1 selects the ROM. The only exception is bits 12:10 = 111 while the remap bit (port bit 4) is 0.
- R3: The scratch RAM is selected only when the enable is high, address bits 12:6 are all ones (0x1FC0–0x1FFF) and port bit 4 is 0.
- R4: The I/O window is selected for 0x0E00–0x0E3F and for its alias 0x0A00–0x0A3F, with the enable high.
- R5: No select is active for 0x0800–0x09FF, 0x0A40–0x0DFF or 0x0E40–0x0FFF. The same holds for 0x1C00–0x1FBF while port bit 4 is 0.
- R6: While the enable is low, every select is inactive and port writes have no effect.
- R7: At most one of the five selects is active in any cycle.
- R8: After reset the port register holds 0xFF, so the vector area reads ROM.
- R9: A write cycle updates the port register at the clock edge, and the new value governs the decode from the next cycle on. A write cycle means enable high, rnw = 0 and write strobe high, at I/O window offset 0x02.
- R10: The port register does not change in four cases: rnw = 1, write strobe low, any other offset in the window, or an address outside the window.
- R11: A write through the alias 0x0A02 updates the port register exactly like a write to 0x0E02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Processor address |
| cen | input | 1 | Chip enable: qualifies all selects and writes |
| rnw | input | 1 | 1 = read, 0 = write |
| wr_stb | input | 1 | Write strobe for the port register |
| wdata | input | 8 | Write data for the port register |
| sel_ram0 | output | 1 | External RAM bank 0 select |
| sel_ram1 | output | 1 | External RAM bank 1 select |
| sel_rom | output | 1 | Internal ROM select |
| sel_iram | output | 1 | Internal scratch RAM select |
| sel_io | output | 1 | I/O window select |
| offs | output | 10 | Offset address to the selected device |
| port_out | output | 8 | Port register value |

## Verification
Two things can meet in the same cycle: a write that changes the remap bit, and the decode that depends on that bit. During the write cycle the decode must still use the old bit, and the new bit applies from the next cycle. The bench provokes this by writing the port register and then presenting 0x1FC0 and 0x1FFF on the very next cycle. Its cycle model applies the new value only after the edge, and it compares every select on every cycle. Full 8192-address sweeps for both bit values check the alias map around that event.

// File: rtl/addr_alias_pkg.sv
`timescale 1ns/1ps
package addr_alias_pkg;

  typedef struct packed {
    logic io;
    logic iram;
    logic rom;
    logic ram1;
    logic ram0;
  } sel_t;

  localparam sel_t SEL_NONE = '0;

endpackage

// File: rtl/amd_reset_sync.sv
`timescale 1ns/1ps
module amd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/amd_bank_decode.sv
`timescale 1ns/1ps
module amd_bank_decode #(
  parameter int IDX_W   = 3,
  parameter int NUM_RAM = 2
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               en,
  output logic [NUM_RAM-1:0] ram_sel,
  output logic               top_slot
);

  localparam logic [IDX_W-1:0] TOP_IDX = '1;

  for (genvar g = 0; g < NUM_RAM; g++) begin : g_bank
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    assign ram_sel[g] = en && (idx == SLOT);
  end

  assign top_slot = (idx == TOP_IDX);

endmodule

// File: rtl/amd_periph_decode.sv
`timescale 1ns/1ps
module amd_periph_decode #(
  parameter int HI_W = 4
) (
  input  logic            en,
  input  logic            region,
  input  logic            ce_a,
  input  logic            ce_b,
  input  logic [HI_W-1:0] hi,
  output logic            rom_sel,
  output logic            iram_sel,
  output logic            io_sel
);

  localparam logic [HI_W-1:0] IRAM_HI = '1;
  localparam logic [HI_W-1:0] IO_HI   = {1'b1, {(HI_W-1){1'b0}}};

  logic live;

  always_comb begin
    live     = en && ce_b;
    rom_sel  = live &&  region &&  ce_a;
    iram_sel = live &&  region && !ce_a && (hi == IRAM_HI);
    io_sel   = live && !region &&  ce_a && (hi == IO_HI);
  end

endmodule

// File: rtl/amd_port_reg.sv
`timescale 1ns/1ps
module amd_port_reg #(
  parameter int           W         = 8,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_VAL;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/addr_alias_decoder.sv
`timescale 1ns/1ps
module addr_alias_decoder #(
  parameter int ADDR_W    = 13,
  parameter int OFS_W     = 10,
  parameter int WIN_W     = 6,
  parameter int PORT_W    = 8,
  parameter int REMAP_BIT = 4,
  parameter int PORT_OFS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cen,
  input  logic              rnw,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wdata,
  output logic              sel_ram0,
  output logic              sel_ram1,
  output logic              sel_rom,
  output logic              sel_iram,
  output logic              sel_io,
  output logic [OFS_W-1:0]  offs,
  output logic [PORT_W-1:0] port_out
);
  import addr_alias_pkg::*;

  localparam int IDX_W = ADDR_W - OFS_W;
  localparam int HI_W  = OFS_W - WIN_W;
  localparam logic [WIN_W-1:0] PORT_SLOT = WIN_W'(PORT_OFS);

  logic             rst_sync_n;
  logic [1:0]       ram_sel;
  logic             top_slot;
  logic             ce_a;
  logic             ce_b;
  logic             remap;
  logic             port_load;
  sel_t             sel;

  amd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  amd_bank_decode #(.IDX_W(IDX_W), .NUM_RAM(2)) u_bank (
    .idx      (addr[ADDR_W-1:OFS_W]),
    .en       (cen),
    .ram_sel  (ram_sel),
    .top_slot (top_slot)
  );

  // peripheral enables: B whenever no RAM bank answers, A gated in top slot
  always_comb begin
    remap = port_out[REMAP_BIT];
    ce_b  = !(ram_sel[0] || ram_sel[1]);
    ce_a  = !top_slot || remap;
  end

  amd_periph_decode #(.HI_W(HI_W)) u_periph (
    .en       (cen),
    .region   (addr[ADDR_W-1]),
    .ce_a     (ce_a),
    .ce_b     (ce_b),
    .hi       (addr[OFS_W-1:WIN_W]),
    .rom_sel  (sel.rom),
    .iram_sel (sel.iram),
    .io_sel   (sel.io)
  );

  always_comb begin
    sel.ram0  = ram_sel[0];
    sel.ram1  = ram_sel[1];
    port_load = sel.io && !rnw && wr_stb && (addr[WIN_W-1:0] == PORT_SLOT);
  end

  amd_port_reg #(.W(PORT_W), .RESET_VAL('1)) u_port (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (port_load),
    .d     (wdata),
    .q     (port_out)
  );

  assign sel_ram0 = sel.ram0;
  assign sel_ram1 = sel.ram1;
  assign sel_rom  = sel.rom;
  assign sel_iram = sel.iram;
  assign sel_io   = sel.io;
  assign offs     = addr[OFS_W-1:0];

endmodule

// File: rtl/addr_alias_decoder_chk.sv
`timescale 1ns/1ps
module addr_alias_decoder_chk #(
  parameter int ADDR_W    = 13,
  parameter int PORT_W    = 8,
  parameter int REMAP_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cen,
  input  logic              rnw,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wdata,
  input  logic              sel_ram0,
  input  logic              sel_ram1,
  input  logic              sel_rom,
  input  logic              sel_iram,
  input  logic              sel_io,
  input  logic [PORT_W-1:0] port_out
);

  logic [4:0] sels;
  logic       wr_hit;

  always_comb begin
    sels   = {sel_io, sel_iram, sel_rom, sel_ram1, sel_ram0};
    wr_hit = cen && !rnw && wr_stb && (addr[12:11] == 2'b01) && (addr[9:0] == 10'h202);
  end

  AST_ONE_HOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels)); // R7

  AST_CEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |-> (sels == 5'b0)); // R6

  AST_IRAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_iram |-> ((addr[12:6] == 7'h7F) && !port_out[REMAP_BIT])); // R3

  AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (port_out == $past(wdata))); // R9

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(port_out)); // R10

  AST_RAM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ram0 || sel_ram1) |-> (addr[12:11] == 2'b00)); // R1

endmodule

bind addr_alias_decoder addr_alias_decoder_chk chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .addr     (addr),
  .cen      (cen),
  .rnw      (rnw),
  .wr_stb   (wr_stb),
  .wdata    (wdata),
  .sel_ram0 (sel_ram0),
  .sel_ram1 (sel_ram1),
  .sel_rom  (sel_rom),
  .sel_iram (sel_iram),
  .sel_io   (sel_io),
  .port_out (port_out)
);

// File: tb/addr_alias_decoder_test.sv
`timescale 1ns/1ps
module addr_alias_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [12:0] addr;
  logic        cen, rnw, wr_stb;
  logic [7:0]  wdata;
  logic        sel_ram0, sel_ram1, sel_rom, sel_iram, sel_io;
  logic [9:0]  offs;
  logic [7:0]  port_out;

  int checks = 0;
  int fails  = 0;
  int model_port = 255;

  addr_alias_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cen(cen), .rnw(rnw),
    .wr_stb(wr_stb), .wdata(wdata), .sel_ram0(sel_ram0), .sel_ram1(sel_ram1),
    .sel_rom(sel_rom), .sel_iram(sel_iram), .sel_io(sel_io), .offs(offs),
    .port_out(port_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected selects as {io, iram, rom, ram1, ram0}
  function automatic logic [4:0] expect_sel(int a, bit c, int pv);
    bit vec_rom = ((pv >> 4) & 1) == 1;
    if (!c) return 5'b00000;
    if (a < 'h400) return 5'b00001;
    if (a < 'h800) return 5'b00010;
    if ((a >= 'hA00 && a < 'hA40) || (a >= 'hE00 && a < 'hE40)) return 5'b10000;
    if (a >= 'h1000) begin
      if (a >= 'h1C00 && !vec_rom) return (a >= 'h1FC0) ? 5'b01000 : 5'b00000;
      return 5'b00100;
    end
    return 5'b00000;
  endfunction

  function automatic string sel_tag(logic [4:0] e, bit c);
    if (!c)      return "R6";
    if (e[0] || e[1]) return "R1";
    if (e[2])    return "R2";
    if (e[3])    return "R3";
    if (e[4])    return "R4";
    return "R5";
  endfunction

  function automatic bit is_hit(int a, bit c, bit rw, bit st);
    bit in_win = (a >= 'hA00 && a < 'hA40) || (a >= 'hE00 && a < 'hE40);
    return c && !rw && st && in_win && ((a % 64) == 2);
  endfunction

  task automatic check(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(int a, bit c, bit rw, bit st, int wd, string ptag);
    logic [4:0] e;
    logic [4:0] g;
    @(negedge clk);
    addr = 13'(a); cen = c; rnw = rw; wr_stb = st; wdata = 8'(wd);
    #1;
    e = expect_sel(a, c, model_port);
    g = {sel_io, sel_iram, sel_rom, sel_ram1, sel_ram0};
    check(g == e, sel_tag(e, c), $sformatf("selects @%0h", a), int'(g), int'(e));
    check(offs == 10'(a), "R1", $sformatf("offset @%0h", a), int'(offs), a % 1024);
    check(port_out == 8'(model_port), ptag, "port_out", int'(port_out), model_port);
    @(posedge clk);
    if (is_hit(a, c, rw, st)) model_port = wd;
  endtask

  task automatic sweep(bit c);
    for (int a = 0; a < 8192; a++) step(a, c, 1'b1, 1'b0, 0, "R10");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; cen = 1'b0; rnw = 1'b1; wr_stb = 1'b0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8: reset value, vector area in ROM
    step('h1FFF, 1, 1, 0, 0, "R8");
    step('h1FC0, 1, 1, 0, 0, "R8");
    // R2/R4/R1/R5 full map with remap bit 1
    sweep(1'b1);

    // R9: clear remap bit, vector area switches on the next cycle
    step('h0E02, 1, 0, 1, 'h00, "R9");
    step('h1FC0, 1, 1, 0, 0, "R9");
    step('h1FFF, 1, 1, 0, 0, "R9");
    step('h1C00, 1, 1, 0, 0, "R5");
    // R3/R5 full map with remap bit 0
    sweep(1'b1);

    // R10: writes that must be ignored
    step('h0E02, 1, 1, 1, 'hFF, "R10");
    step('h0E02, 1, 0, 0, 'hFF, "R10");
    step('h0E03, 1, 0, 1, 'hFF, "R10");
    step('h0E00, 1, 0, 1, 'hFF, "R10");
    step('h1E02, 1, 0, 1, 'hFF, "R10");
    step('h0602, 1, 0, 1, 'hFF, "R10");
    step('h1FFF, 1, 1, 0, 0, "R10");
    // R6: enable low, no selects and no write
    step('h0E02, 0, 0, 1, 'hFF, "R6");
    step('h1FC0, 1, 1, 0, 0, "R6");
    for (int a = 0; a < 8192; a += 61) step(a, 1'b0, 1'b1, 1'b0, 0, "R6");

    // R11: alias write sets the bit back
    step('h0A02, 1, 0, 1, 'hFF, "R11");
    step('h1FC0, 1, 1, 0, 0, "R11");
    step('h1FFF, 1, 1, 0, 0, "R11");
    // R9: only bit 4 governs the remap
    step('h0E02, 1, 0, 1, 'hEF, "R9");
    step('h1FE0, 1, 1, 0, 0, "R9");
    step('h0E02, 1, 0, 1, 'h10, "R9");
    step('h1FE0, 1, 1, 0, 0, "R9");
    // back-to-back writes through both aliases
    step('h0A02, 1, 0, 1, 'h00, "R11");
    step('h0E02, 1, 0, 1, 'h5A, "R9");
    step('h1FC1, 1, 1, 0, 0, "R9");
    step('h0A42, 1, 0, 1, 'hFF, "R10");
    step('h0A3F, 1, 1, 0, 0, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule